// File: doc/BRIEF.md
# Hysteretic Ground-Key Filter

This block cleans up a slow supervision input, typically a ground-key or secondary line-detect signal, before it is used. The raw level is first brought into the clock domain through a short synchroniser. A programmable divider then counts strobes from a free-running 1 kHz tick and produces one filter step every 1 to 15 ms, chosen by a 4-bit setting.

On each filter step, a small integrator with six states (0 to 5) moves one state toward the current input level. The filtered output rises only when the integrator reaches its top state and falls only when it reaches its bottom state. Short glitches are therefore absorbed, and a level has to persist for several steps before the output changes. A setting of zero turns the filter off, and the synchronised input then goes straight to the output.

Top module: `hyst_key_filter`

## Requirements
- R1: With a setting N in 1..15, the first 1 kHz strobe after reset or after bypass performs a filter step, and after that a step occurs on every N-th strobe. Cycles without a strobe never change the integrator.
- R2: With a setting of 0 the output equals the raw input delayed by the two synchroniser flops, with no strobe required. While the setting is 0 the integrator is held at 0 and the output state is held low, so the filtered output reads low on the first cycle after a non-zero setting is applied.
- R3: On a filter step the integrator increments by one when the synchronised input is 1 and decrements by one when it is 0.
- R4: The integrator stays in 0..5. It saturates at 5 when driven up and at 0 when driven down, and never wraps.
- R5: When the integrator reaches 5 the output goes to 1, and it stays 1 until the integrator returns to 0.
- R6: When the integrator reaches 0 the output goes to 0, and it stays 0 until the integrator reaches 5 again.
- R7: A new non-zero setting applied mid-period does not shorten or lengthen the period already running. It is loaded only when the current period expires.
- R8: An active-low asynchronous reset clears the integrator to 0, the divider to its expired state and the output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | One-cycle strobe at 1 kHz |
| rate_sel | input | 4 | Filter period in ms (1..15), 0 selects bypass |
| raw_in | input | 1 | Asynchronous detect input |
| filt_out | output | 1 | Filtered detect output |

## Verification
The checker watches the following on every cycle:
- the integrator staying within 0..5;
- the output state agreeing with the top and bottom states;
- single-step movement on each filter step, including saturation;
- the integrator being frozen between strobes and cleared while bypassed.

Some properties can only be shown by the bench's scenarios, because they span many strobes and are visible only at the output. These are the exact spacing of steps for a given setting, the deferred loading of a changed setting, and the hysteresis seen across long sequences of up and down steps.

// File: rtl/hkf_pkg.sv
package hkf_pkg;
   localparam int unsigned HKF_SEL_W     = 4;
   localparam int unsigned HKF_TOP_STATE = 5;
   localparam int unsigned HKF_SYNC_LEN  = 2;

   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } hkf_level_e;
endpackage

// File: rtl/hkf_sync.sv
module hkf_sync #(
   parameter int unsigned STAGES = hkf_pkg::HKF_SYNC_LEN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= d_in;
               for (int i = 1; i < int'(STAGES); i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign q_out = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hkf_divider.sv
module hkf_divider #(
   parameter int unsigned SEL_W = hkf_pkg::HKF_SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_in,
   input  logic [SEL_W-1:0] sel,
   output logic             step_o
);
   localparam logic [SEL_W-1:0] ONE  = {{(SEL_W-1){1'b0}}, 1'b1};
   localparam logic [SEL_W-1:0] ZERO = '0;

   logic [SEL_W-1:0] remain_q;
   logic             bypass;
   logic             expired;

   assign bypass  = (sel == ZERO);
   assign expired = (remain_q == ZERO);
   assign step_o  = tick_in && !bypass && expired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= ZERO;
      end else if (bypass) begin
         remain_q <= ZERO;
      end else if (tick_in) begin
         if (expired) remain_q <= sel - ONE;
         else         remain_q <= remain_q - ONE;
      end
   end
endmodule

// File: rtl/hkf_integrator.sv
module hkf_integrator #(
   parameter int unsigned TOP_STATE = hkf_pkg::HKF_TOP_STATE,
   localparam int unsigned CNT_W    = $clog2(TOP_STATE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             up,
   output logic [CNT_W-1:0] level_q,
   output logic             state_q
);
   localparam logic [CNT_W-1:0] TOP_C = CNT_W'(TOP_STATE);
   localparam logic [CNT_W-1:0] BOT_C = '0;
   localparam logic [CNT_W-1:0] INC_C = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] level_d;
   logic             state_d;

   always_comb begin
      level_d = level_q;
      if (up && level_q != TOP_C)      level_d = level_q + INC_C;
      else if (!up && level_q != BOT_C) level_d = level_q - INC_C;
      state_d = state_q;
      if (level_d == TOP_C)      state_d = hkf_pkg::LVL_HIGH;
      else if (level_d == BOT_C) state_d = hkf_pkg::LVL_LOW;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= BOT_C;
         state_q <= hkf_pkg::LVL_LOW;
      end else if (clr) begin
         level_q <= BOT_C;
         state_q <= hkf_pkg::LVL_LOW;
      end else if (step) begin
         level_q <= level_d;
         state_q <= state_d;
      end
   end
endmodule

// File: rtl/hyst_key_filter.sv
module hyst_key_filter #(
   parameter int unsigned SEL_W     = hkf_pkg::HKF_SEL_W,
   parameter int unsigned TOP_STATE = hkf_pkg::HKF_TOP_STATE,
   parameter int unsigned SYNC_LEN  = hkf_pkg::HKF_SYNC_LEN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_1k,
   input  logic [SEL_W-1:0] rate_sel,
   input  logic             raw_in,
   output logic             filt_out
);
   localparam int unsigned CNT_W = $clog2(TOP_STATE + 1);

   generate
      if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel
         $error("hyst_key_filter: SEL_W out of range");
      end
      if (TOP_STATE < 1) begin : g_bad_top
         $error("hyst_key_filter: TOP_STATE must be at least 1");
      end
   endgenerate

   logic             in_sync;
   logic             step;
   logic             bypass;
   logic [CNT_W-1:0] level_q;
   logic             state_q;

   assign bypass = (rate_sel == '0);

   hkf_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_in),
      .q_out (in_sync)
   );

   hkf_divider #(.SEL_W(SEL_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_in (tick_1k),
      .sel     (rate_sel),
      .step_o  (step)
   );

   hkf_integrator #(.TOP_STATE(TOP_STATE)) u_int (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (bypass),
      .step    (step),
      .up      (in_sync),
      .level_q (level_q),
      .state_q (state_q)
   );

   assign filt_out = bypass ? in_sync : state_q;
endmodule

// File: rtl/hyst_key_filter_chk.sv
module hyst_key_filter_chk #(
   parameter int unsigned TOP_STATE = hkf_pkg::HKF_TOP_STATE,
   parameter int unsigned CNT_W     = $clog2(TOP_STATE + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_1k,
   input logic             bypass,
   input logic             step,
   input logic             up,
   input logic [CNT_W-1:0] level_q,
   input logic             state_q
);
   localparam logic [CNT_W-1:0] TOP_C = CNT_W'(TOP_STATE);

   a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= TOP_C);

   a_r5_high_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q == TOP_C) |-> state_q);

   a_r6_low_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q == '0) |-> !state_q);

   a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (step && up && level_q != TOP_C && !bypass) |=> (level_q == $past(level_q) + 1'b1));

   a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !up && level_q != '0 && !bypass) |=> (level_q == $past(level_q) - 1'b1));

   a_r4_saturate_top: assert property (@(posedge clk) disable iff (!rst_n)
      (step && up && level_q == TOP_C) |=> (level_q == TOP_C));

   a_r1_idle_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_1k && !bypass) |=> $stable(level_q));

   a_r2_bypass_clears: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> (level_q == '0 && !state_q));
endmodule

bind hyst_key_filter hyst_key_filter_chk #(.TOP_STATE(TOP_STATE)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_1k (tick_1k),
   .bypass  (bypass),
   .step    (step),
   .up      (in_sync),
   .level_q (level_q),
   .state_q (state_q)
);

// File: tb/hyst_key_filter_tb_top.sv
module hyst_key_filter_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC       = 13;

   // {rate[3:0], level, ticks[7:0], expected output}
   localparam logic [13:0] VEC [NVEC] = '{
      {4'd1, 1'b1, 8'd4, 1'b0},   // R3 climb to 4
      {4'd1, 1'b1, 8'd1, 1'b1},   // R5 reach top
      {4'd1, 1'b1, 8'd3, 1'b1},   // R4 saturate at top
      {4'd1, 1'b0, 8'd4, 1'b1},   // R5 hold while falling to 1
      {4'd1, 1'b1, 8'd3, 1'b1},   // R4 back to 4 (no wrap earlier)
      {4'd1, 1'b0, 8'd4, 1'b0},   // R6 reach bottom
      {4'd1, 1'b0, 8'd2, 1'b0},   // R4 saturate at bottom
      {4'd1, 1'b1, 8'd1, 1'b0},   // R6 hold at 1
      {4'd1, 1'b1, 8'd3, 1'b0},   // R6 hold at 4
      {4'd1, 1'b1, 8'd1, 1'b1},   // R5 top again
      {4'd3, 1'b0, 8'd3, 1'b1},   // R1 one step in 3 strobes
      {4'd3, 1'b0, 8'd6, 1'b1},   // R1 two steps in 6 strobes
      {4'd3, 1'b0, 8'd4, 1'b0}    // R1 steps on strobes 1 and 4
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1k = 1'b0;
   logic [3:0] rate_sel = 4'd0;
   logic       raw_in = 1'b0;
   logic       filt_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hyst_key_filter dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_1k  (tick_1k),
      .rate_sel (rate_sel),
      .raw_in   (raw_in),
      .filt_out (filt_out)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: filt_out=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_level(input logic lvl);
      raw_in = lvl;
      repeat (3) @(negedge clk);
   endtask

   task automatic strobes(input int n);
      for (int k = 0; k < n; k++) begin
         tick_1k = 1'b1;
         @(negedge clk);
         tick_1k = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      rate_sel = 4'd1;
      raw_in   = 1'b0;
      do_reset();
      check("R8 reset low", filt_out, 1'b0);

      // vector walk
      for (int i = 0; i < NVEC; i++) begin
         rate_sel = VEC[i][13:10];
         set_level(VEC[i][9]);
         strobes(int'(VEC[i][8:1]));
         check($sformatf("R1/R3/R4/R5/R6 vector %0d", i), filt_out, VEC[i][0]);
      end

      // R2: bypass passes synchronised input without strobes
      do_reset();
      rate_sel = 4'd0;
      set_level(1'b1);
      check("R2 bypass high", filt_out, 1'b1);
      set_level(1'b0);
      check("R2 bypass low", filt_out, 1'b0);
      set_level(1'b1);
      check("R2 bypass high again", filt_out, 1'b1);
      // leaving bypass: state cleared
      rate_sel = 4'd1;
      @(negedge clk);
      check("R2 cleared on exit", filt_out, 1'b0);
      strobes(4);
      check("R2 restart from 0 (4 steps)", filt_out, 1'b0);
      strobes(1);
      check("R2 restart reaches top", filt_out, 1'b1);

      // R1: longest period, steps on strobes 1,16,31,46,61
      do_reset();
      rate_sel = 4'd15;
      set_level(1'b1);
      strobes(60);
      check("R1 period 15 not yet", filt_out, 1'b0);
      strobes(1);
      check("R1 period 15 fifth step", filt_out, 1'b1);

      // R7: new setting waits for the running period
      do_reset();
      rate_sel = 4'd1;
      set_level(1'b1);
      strobes(3);                 // level 3, divider expired
      rate_sel = 4'd8;
      strobes(1);                 // step -> 4, period of 8 starts
      rate_sel = 4'd1;
      strobes(7);                 // period still running
      check("R7 old period kept", filt_out, 1'b0);
      strobes(1);                 // expiry -> step -> 5
      check("R7 step at period end", filt_out, 1'b1);

      // R8: reset mid-operation clears output
      do_reset();
      check("R8 reset clears high output", filt_out, 1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule